// File: doc/BRIEF.md
# DMA Channel Register Window

This block gives software a compact, relocatable 16-byte register window for one of eight legacy DMA channels. Software issues byte reads and writes at window offsets 0x0 to 0xF; the block keeps its own shadow copies of the channel's base and current address, base and current count, and page byte. It converts control writes into single-byte write transactions on a forwarded-port master interface that addresses the legacy controller's scattered port space.

The channel number on `chan_i` selects the target controller. Channels 0 to 3 use the low controller, with ports from 0x00. Channels 4 to 7 use the high controller, with ports from 0xC0. Page writes are remapped to the page-register port block. A mask-all command expands into a short burst of forwarded writes. While a burst or a forwarded read is in flight, the block raises `busy_o` and refuses new register accesses.

Top module: `ddma_xlat`

## Requirements
- R1: After reset, all shadows are zero, `busy_o`, `reg_rvalid_o`, `fwd_wr_o` and `fwd_rd_o` are low, and reads of offsets 0x0, 0x1, 0x2, 0x4 and 0x5 return 0x00.
- R2: A write to offset 0x0 replaces bits 7:0 of the base address, and a write to 0x1 replaces bits 15:8. Either write reloads the current address from the new base. Reads of 0x0 and 0x1 return current-address bits 7:0 and 15:8. Neither write forwards anything.
- R3: Offsets 0x4 and 0x5 do the same for the count: bits 7:0 and 15:8, with the current count reloaded and read back, and no forwarded transaction.
- R4: A write to offset 0x2 stores the page byte, which reads back at 0x2. It also forwards the byte to port P + S. P is 0x80 for channels 0-3 and 0x88 for channels 4-7. S is 7, 3, 1 or 2 for channel bits 1:0 equal to 0, 1, 2 or 3.
- R5: A write to offset 0x8, 0x9, 0xA, 0xB or 0xD forwards the written byte to controller base + offset. The controller base is 0x00 for channels 0-3 and 0xC0 for channels 4-7.
- R6: A write to offset 0xE forwards four writes to controller base + 0x0A on four consecutive cycles, carrying 0, 1, 2 and 3. `busy_o` is high during the first three of these cycles.
- R7: A write of value v to offset 0xF forwards ((v << 2) | channel[1:0]) mod 256 to controller base + 0x0A.
- R8: A read of offset 0x9 drives `fwd_rd_o` for one cycle at controller base + 0x08, with `busy_o` high. On the next cycle, `reg_rvalid_o` is high and `reg_rdata_o` holds the `fwd_rdata_i` value that was sampled while `fwd_rd_o` was high.
- R9: Reads of offsets other than 0x0, 0x1, 0x2, 0x4, 0x5 and 0x9 return 0xFF. Writes to 0x3, 0x6, 0x7, 0xC and 0xE produce no single forwarded write and leave the shadows unchanged. Offset 0xE gives only its burst (R6).
- R10: While `busy_o` is high, register reads and writes are refused. They change no shadow, forward nothing, and give no read response. Forwarded write and read strobes are never high together.
- R11: An accepted shadow read gives `reg_rvalid_o` high with its data one cycle after the strobe. When `reg_wr_i` and `reg_rd_i` are high together, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_i | input | 3 | Channel served by this window |
| reg_addr_i | input | 4 | Window offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 8 | Read data |
| reg_rvalid_o | output | 1 | Read data valid pulse |
| busy_o | output | 1 | Sequence in flight; accesses refused |
| fwd_wr_o | output | 1 | Forwarded write strobe |
| fwd_rd_o | output | 1 | Forwarded read strobe |
| fwd_addr_o | output | 8 | Forwarded port address |
| fwd_wdata_o | output | 8 | Forwarded write data |
| fwd_rdata_i | input | 8 | Forwarded read data, valid while fwd_rd_o is high |

## Verification
Two pairs of events can land in the same cycle. The first is a new register write or read that arrives while a mask burst or forwarded status read is still running. The bench holds a write to offset 0x0 asserted across the whole burst and then reads the address back unchanged. It also injects a write during a forwarded read and confirms that no forwarded write appears. The second pair is simultaneous read and write strobes. The bench checks that no read response comes out and that the written count byte reads back afterwards. The bench also sweeps all eight channels over all sixteen offsets, with the expected forwarded addresses and data computed arithmetically.

// File: rtl/ddma_xlat_pkg.sv
package ddma_xlat_pkg;
  localparam int BYTE_W    = 8;
  localparam int SHADOW_W  = 16;
  localparam int OFF_W     = 4;
  localparam int CHAN_W    = 3;
  localparam int BURST_LEN = 4;
  localparam int IDX_W     = $clog2(BURST_LEN);

  localparam logic [BYTE_W-1:0] CTL_LO_BASE  = 8'h00;
  localparam logic [BYTE_W-1:0] CTL_HI_BASE  = 8'hC0;
  localparam logic [BYTE_W-1:0] PAGE_LO_BASE = 8'h80;
  localparam logic [BYTE_W-1:0] PAGE_HI_BASE = 8'h88;
  localparam logic [BYTE_W-1:0] MASK_PORT    = 8'h0A;
  localparam logic [BYTE_W-1:0] STAT_PORT    = 8'h08;

  typedef enum logic [1:0] {FWD_NONE, FWD_WR, FWD_BURST, FWD_RD} fwd_kind_e;

  // page-port slot per channel within a controller
  function automatic logic [BYTE_W-1:0] page_slot(input logic [1:0] c);
    case (c)
      2'd0:    page_slot = 8'd7;
      2'd1:    page_slot = 8'd3;
      2'd2:    page_slot = 8'd1;
      default: page_slot = 8'd2;
    endcase
  endfunction
endpackage

// File: rtl/ddma_xlat_decode.sv
module ddma_xlat_decode
  import ddma_xlat_pkg::*;
(
  input  logic [CHAN_W-1:0]   chan_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic [SHADOW_W-1:0] cur_addr_i,
  input  logic [SHADOW_W-1:0] cur_cnt_i,
  input  logic [BYTE_W-1:0]   page_i,
  output fwd_kind_e           wr_kind_o,
  output logic [BYTE_W-1:0]   wr_addr_o,
  output logic [BYTE_W-1:0]   wr_data_o,
  output logic [3:0]          shadow_we_o,
  output logic                page_we_o,
  output logic                rd_fwd_o,
  output logic [BYTE_W-1:0]   rd_addr_o,
  output logic [BYTE_W-1:0]   rd_data_o
);
  logic [BYTE_W-1:0] ctl_base;
  logic [BYTE_W-1:0] page_base;

  assign ctl_base  = chan_i[CHAN_W-1] ? CTL_HI_BASE  : CTL_LO_BASE;
  assign page_base = chan_i[CHAN_W-1] ? PAGE_HI_BASE : PAGE_LO_BASE;
  assign rd_addr_o = ctl_base + STAT_PORT;

  always_comb begin
    wr_kind_o   = FWD_NONE;
    wr_addr_o   = ctl_base + {{(BYTE_W-OFF_W){1'b0}}, off_i};
    wr_data_o   = wdata_i;
    shadow_we_o = '0;
    page_we_o   = 1'b0;
    case (off_i)
      4'h0: shadow_we_o[0] = 1'b1;
      4'h1: shadow_we_o[1] = 1'b1;
      4'h4: shadow_we_o[2] = 1'b1;
      4'h5: shadow_we_o[3] = 1'b1;
      4'h2: begin
        page_we_o = 1'b1;
        wr_kind_o = FWD_WR;
        wr_addr_o = page_base + page_slot(chan_i[1:0]);
      end
      4'h8, 4'h9, 4'hA, 4'hB, 4'hD: wr_kind_o = FWD_WR;
      4'hE: begin
        wr_kind_o = FWD_BURST;
        wr_addr_o = ctl_base + MASK_PORT;
      end
      4'hF: begin
        wr_kind_o = FWD_WR;
        wr_addr_o = ctl_base + MASK_PORT;
        wr_data_o = {wdata_i[BYTE_W-3:0], chan_i[1:0]};
      end
      default: ;
    endcase
  end

  always_comb begin
    rd_fwd_o  = 1'b0;
    rd_data_o = '1;
    case (off_i)
      4'h0: rd_data_o = cur_addr_i[7:0];
      4'h1: rd_data_o = cur_addr_i[15:8];
      4'h2: rd_data_o = page_i;
      4'h4: rd_data_o = cur_cnt_i[7:0];
      4'h5: rd_data_o = cur_cnt_i[15:8];
      4'h9: rd_fwd_o  = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/ddma_xlat_shadow.sv
module ddma_xlat_shadow
  import ddma_xlat_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [3:0]          we_i,      // {cnt_hi, cnt_lo, addr_hi, addr_lo}
  input  logic                page_we_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [SHADOW_W-1:0] cur_addr_o,
  output logic [SHADOW_W-1:0] cur_cnt_o,
  output logic [BYTE_W-1:0]   page_o
);
  logic [1:0][SHADOW_W-1:0] cur;

  for (genvar g = 0; g < 2; g++) begin : g_pair
    logic [SHADOW_W-1:0] base_q, cur_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        cur_q  <= '0;
      end else if (we_i[2*g]) begin
        base_q[7:0] <= wdata_i;
        cur_q       <= {base_q[15:8], wdata_i};
      end else if (we_i[2*g+1]) begin
        base_q[15:8] <= wdata_i;
        cur_q        <= {wdata_i, base_q[7:0]};
      end
    end
    assign cur[g] = cur_q;

    // R2 / R3: any byte write reloads current from base
    p_reload_r2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i[2*g] || we_i[2*g+1]) |=> (cur_q == base_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        page_o <= '0;
    else if (page_we_i) page_o <= wdata_i;
  end

  assign cur_addr_o = cur[0];
  assign cur_cnt_o  = cur[1];
endmodule

// File: rtl/ddma_xlat_seq.sv
module ddma_xlat_seq
  import ddma_xlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fwd_kind_e         kind_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              fwd_wr_o,
  output logic              fwd_rd_o,
  output logic [BYTE_W-1:0] fwd_addr_o,
  output logic [BYTE_W-1:0] fwd_wdata_o,
  output logic              busy_o
);
  typedef enum logic [1:0] {S_IDLE, S_BURST, S_RD} state_e;
  state_e           state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      idx_q       <= '0;
      fwd_wr_o    <= 1'b0;
      fwd_rd_o    <= 1'b0;
      fwd_addr_o  <= '0;
      fwd_wdata_o <= '0;
    end else begin
      fwd_wr_o <= 1'b0;
      fwd_rd_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          case (kind_i)
            FWD_WR: begin
              fwd_wr_o    <= 1'b1;
              fwd_addr_o  <= addr_i;
              fwd_wdata_o <= data_i;
            end
            FWD_BURST: begin
              fwd_wr_o    <= 1'b1;
              fwd_addr_o  <= addr_i;
              fwd_wdata_o <= '0;
              idx_q       <= IDX_W'(1);
              state_q     <= S_BURST;
            end
            FWD_RD: begin
              fwd_rd_o   <= 1'b1;
              fwd_addr_o <= addr_i;
              state_q    <= S_RD;
            end
            default: ;
          endcase
        end
        S_BURST: begin
          fwd_wr_o    <= 1'b1;
          fwd_wdata_o <= {{(BYTE_W-IDX_W){1'b0}}, idx_q};
          idx_q       <= idx_q + 1'b1;
          if (idx_q == IDX_W'(BURST_LEN-1)) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);

  // R6: every busy cycle carries a forwarded strobe
  p_busy_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (fwd_wr_o || fwd_rd_o));
  // R8: forwarded reads target the status port
  p_rd_port_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_rd_o |-> (fwd_addr_o[3:0] == STAT_PORT[3:0]));
endmodule

// File: rtl/ddma_xlat.sv
module ddma_xlat
  import ddma_xlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [OFF_W-1:0]  reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              busy_o,
  output logic              fwd_wr_o,
  output logic              fwd_rd_o,
  output logic [BYTE_W-1:0] fwd_addr_o,
  output logic [BYTE_W-1:0] fwd_wdata_o,
  input  logic [BYTE_W-1:0] fwd_rdata_i
);
  logic                acc_wr, acc_rd;
  fwd_kind_e           wr_kind, seq_kind;
  logic [BYTE_W-1:0]   wr_addr, wr_data, rd_addr, rd_data, seq_addr, page;
  logic [3:0]          dec_we;
  logic                dec_page_we, rd_fwd;
  logic [SHADOW_W-1:0] cur_addr, cur_cnt;

  assign acc_wr = reg_wr_i && !busy_o;
  assign acc_rd = reg_rd_i && !reg_wr_i && !busy_o;

  ddma_xlat_decode u_decode (
    .chan_i     (chan_i),
    .off_i      (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .cur_addr_i (cur_addr),
    .cur_cnt_i  (cur_cnt),
    .page_i     (page),
    .wr_kind_o  (wr_kind),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .shadow_we_o(dec_we),
    .page_we_o  (dec_page_we),
    .rd_fwd_o   (rd_fwd),
    .rd_addr_o  (rd_addr),
    .rd_data_o  (rd_data)
  );

  ddma_xlat_shadow u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (acc_wr ? dec_we : 4'b0),
    .page_we_i (acc_wr && dec_page_we),
    .wdata_i   (reg_wdata_i),
    .cur_addr_o(cur_addr),
    .cur_cnt_o (cur_cnt),
    .page_o    (page)
  );

  always_comb begin
    seq_kind = FWD_NONE;
    seq_addr = wr_addr;
    if (acc_wr) begin
      seq_kind = wr_kind;
    end else if (acc_rd && rd_fwd) begin
      seq_kind = FWD_RD;
      seq_addr = rd_addr;
    end
  end

  ddma_xlat_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (seq_kind),
    .addr_i     (seq_addr),
    .data_i     (wr_data),
    .fwd_wr_o   (fwd_wr_o),
    .fwd_rd_o   (fwd_rd_o),
    .fwd_addr_o (fwd_addr_o),
    .fwd_wdata_o(fwd_wdata_o),
    .busy_o     (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o  <= '0;
      reg_rvalid_o <= 1'b0;
    end else begin
      reg_rvalid_o <= 1'b0;
      if (fwd_rd_o) begin
        reg_rdata_o  <= fwd_rdata_i;
        reg_rvalid_o <= 1'b1;
      end else if (acc_rd && !rd_fwd) begin
        reg_rdata_o  <= rd_data;
        reg_rvalid_o <= 1'b1;
      end
    end
  end

  // R8: forwarded read is answered on the next cycle
  p_rd_return_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_rd_o |=> reg_rvalid_o);
  // R10: strobes exclusive
  p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_wr_o && fwd_rd_o));
  // R10: refused writes leave shadows alone
  p_refuse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_wr_i) |=> ($stable(cur_addr) && $stable(cur_cnt) && $stable(page)));
  // R11: write wins over simultaneous read
  p_wr_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_rd_i && !busy_o) |=> !reg_rvalid_o);
endmodule

// File: tb/ddma_xlat_tb_top.sv
module ddma_xlat_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] chan_i = '0;
  logic [3:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0] reg_rdata_o, fwd_addr_o, fwd_wdata_o, fwd_rdata_i;
  logic       reg_rvalid_o, busy_o, fwd_wr_o, fwd_rd_o;

  int checks = 0, fails = 0;
  logic [15:0] m_addr = '0, m_cnt = '0;
  logic [7:0]  m_page = '0;

  always #10 clk_i = ~clk_i;

  assign fwd_rdata_i = 8'h96 ^ {5'b0, chan_i};

  ddma_xlat dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, act, exp);
    end
  endtask

  function automatic int ctl_base(input int ch);
    return (ch >= 4) ? 192 : 0;
  endfunction

  task automatic do_wr(input logic [3:0] off, input logic [7:0] v);
    @(negedge clk_i);
    reg_addr_i = off; reg_wdata_i = v; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] off, output logic [7:0] d, output logic v,
                       output logic frd, output logic [7:0] fa);
    @(negedge clk_i);
    reg_addr_i = off; reg_rd_i = 1'b1;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
    frd = fwd_rd_o; fa = fwd_addr_o;
    if (frd) @(negedge clk_i);
    d = reg_rdata_o; v = reg_rvalid_o;
  endtask

  task automatic wr_and_check(input int ch, input int off, input logic [7:0] v);
    int ea, ed, pslot;
    do_wr(off[3:0], v);
    case (off)
      0: m_addr[7:0] = v;
      1: m_addr[15:8] = v;
      4: m_cnt[7:0] = v;
      5: m_cnt[15:8] = v;
      2: m_page = v;
      default: ;
    endcase
    if (off == 2) begin
      pslot = ((ch & 3) == 0) ? 7 : ((ch & 3) == 1) ? 3 : ((ch & 3) == 2) ? 1 : 2;
      ea = ((ch >= 4) ? 136 : 128) + pslot;
      chk(fwd_wr_o && fwd_addr_o == ea[7:0] && fwd_wdata_o == v, "R4", "page fwd addr", fwd_addr_o, ea);
    end else if (off == 8 || off == 9 || off == 10 || off == 11 || off == 13) begin
      ea = ctl_base(ch) + off;
      chk(fwd_wr_o && fwd_addr_o == ea[7:0] && fwd_wdata_o == v, "R5", "pass fwd addr", fwd_addr_o, ea);
    end else if (off == 15) begin
      ea = ctl_base(ch) + 10;
      ed = ((v << 2) | (ch & 3)) & 255;
      chk(fwd_wr_o && fwd_addr_o == ea[7:0] && fwd_wdata_o == ed[7:0], "R7", "mask value", fwd_wdata_o, ed);
    end else if (off == 14) begin
      ea = ctl_base(ch) + 10;
      for (int k = 0; k < 4; k++) begin
        if (k > 0) @(negedge clk_i);
        chk(fwd_wr_o && fwd_addr_o == ea[7:0] && fwd_wdata_o == k[7:0] && busy_o == (k < 3),
            "R6", "burst step", fwd_wdata_o, k);
      end
    end else begin
      chk(!fwd_wr_o && !fwd_rd_o, (off inside {0, 1}) ? "R2" : (off inside {4, 5}) ? "R3" : "R9",
          "no fwd", fwd_wr_o, 0);
    end
    chk(!reg_rvalid_o, "R11", "no rvalid on write", reg_rvalid_o, 0);
  endtask

  task automatic rd_and_check(input int ch, input int off);
    logic [7:0] d, fa; logic v, frd; int e;
    do_rd(off[3:0], d, v, frd, fa);
    case (off)
      0: e = m_addr[7:0];
      1: e = m_addr[15:8];
      2: e = m_page;
      4: e = m_cnt[7:0];
      5: e = m_cnt[15:8];
      9: e = 8'h96 ^ ch;
      default: e = 255;
    endcase
    if (off == 9)
      chk(frd && fa == ctl_base(ch) + 8, "R8", "fwd read addr", fa, ctl_base(ch) + 8);
    chk(v && d == e[7:0], (off inside {0, 1}) ? "R2" : (off inside {4, 5}) ? "R3" :
        (off == 2) ? "R4" : (off == 9) ? "R8" : "R9", "read data", d, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got 0 exp 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, fa; logic v, frd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(!busy_o && !reg_rvalid_o && !fwd_wr_o && !fwd_rd_o, "R1", "idle outputs", busy_o, 0);
    foreach (m_page[i]) ;
    for (int o = 0; o < 6; o++)
      if (o != 3) begin
        do_rd(o[3:0], d, v, frd, fa);
        chk(v && d == 8'h00, "R1", "reset read", d, 0);
      end

    // sweep all channels and offsets
    for (int ch = 0; ch < 8; ch++) begin
      chan_i = ch[2:0];
      for (int off = 0; off < 16; off++)
        wr_and_check(ch, off, 8'((ch * 37 + off * 11 + 8'h5C) & 255));
      for (int off = 0; off < 16; off++)
        rd_and_check(ch, off);
    end

    // R10: write held across a mask burst is refused
    chan_i = 3'd5;
    do_wr(4'hE, 8'h00);
    reg_addr_i = 4'h0; reg_wdata_i = 8'hEE; reg_wr_i = 1'b1;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk_i);
      chk(fwd_wr_o && fwd_wdata_o == k[7:0], "R10", "burst under pressure", fwd_wdata_o, k);
    end
    reg_wr_i = 1'b0;
    rd_and_check(5, 0);

    // R10: write during forwarded read is refused
    @(negedge clk_i);
    reg_addr_i = 4'h9; reg_rd_i = 1'b1;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
    chk(fwd_rd_o && busy_o, "R10", "fwd read busy", busy_o, 1);
    reg_addr_i = 4'h8; reg_wdata_i = 8'h77; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    chk(reg_rvalid_o && reg_rdata_o == (8'h96 ^ 8'd5), "R8", "read return", reg_rdata_o, 8'h96 ^ 8'd5);
    chk(!fwd_wr_o, "R10", "refused write not forwarded", fwd_wr_o, 0);

    // R11: simultaneous read and write
    @(negedge clk_i);
    reg_addr_i = 4'h4; reg_wdata_i = 8'h3C; reg_wr_i = 1'b1; reg_rd_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_rd_i = 1'b0;
    chk(!reg_rvalid_o, "R11", "read dropped", reg_rvalid_o, 0);
    m_cnt[7:0] = 8'h3C;
    rd_and_check(5, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule